// File: doc/BRIEF.md
# STS-3 Transmit Overhead and Parity Generator

This block takes three frame-aligned STS-1 byte streams and builds the outgoing STS-3 byte stream from them. Each input transfer carries one byte from each tributary. The block sends the three bytes out one after another, in tributary order. It then writes the section and line overhead into columns 1 to 9 of every row and leaves columns 10 to 270 as interleaved payload. It computes the B1 parity (BIP-8) and the per-tributary B2 parity (BIP-24), and can apply the frame-synchronous scrambler with polynomial 1 + x^6 + x^7. In concatenated (AU-4) mode it writes the fixed pointer and concatenation bytes in place of the pass-through H1 to H3.

Both data edges are valid/ready streams. The input takes a word when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` goes high only when the internal holding word is empty, or when its last byte is leaving in that cycle. So one input word is taken for every three output bytes. On the output, a byte that is presented while `out_ready` is low stays on `out_data` unchanged until it is taken. The output never drops a byte and never repeats one. A word with `in_sof` high marks row 1, column 1 of a frame, and the byte position counter restarts from that word. The provisioning inputs are plain levels and are expected to stay static while traffic flows.

Top module: `sts3_oh_tx`

## Requirements
- R1: Output columns 10 to 270 (0-based columns 9 to 269) carry payload. Column c carries the byte of tributary c mod 3 (bits [8k+7:8k] of the input word for tributary k), and the bytes leave in tributary order 0, 1, 2.
- R2: Row 1 is never scrambled. Columns 1 to 3 of row 1 are 0xF6 and columns 4 to 6 are 0x28. Column 7 is `cfg_j0`, column 8 is `cfg_z0[7:0]` and column 9 is `cfg_z0[15:8]`.
- R3: A byte presented with `out_ready` low stays valid and unchanged in the next cycle. After reset `out_valid` is 0 and `in_ready` is 1.
- R4: With `cfg_au4` = 0, the row 4 bytes in columns 1 to 9 (the H1, H2 and H3 bytes) pass through from their tributaries.
- R5: With `cfg_au4` = 1, row 4 carries 0x6A, 0x9B, 0x9B in columns 1 to 3, then 0x0A, 0xFF, 0xFF in columns 4 to 6, then 0xFF in columns 7 to 9.
- R6: Row 5 column 4 is `cfg_k1` and row 5 column 7 is `cfg_k2`. Row 9 column 1 is `cfg_s1` and row 9 column 6 is `rx_b2_err`.
- R7: All other overhead bytes are filled as follows. With `cfg_fill_pass` = 1 they carry the tributary byte. Otherwise they carry 0xFF when `cfg_sdh` = 1 and 0x00 when it is 0.
- R8: Row 2 column 1 carries the XOR of all output bytes of the previous frame, taken after scrambling. It is inserted before scrambling. In the first frame after reset it is 0x00.
- R9: Row 5 column t+1 (t = 0, 1, 2) carries the XOR of the previous frame's pre-scrambling bytes in every column c with c mod 3 = t, leaving out rows 1 to 3 of columns 1 to 9.
- R10: `cfg_inv_b1` inverts the inserted B1 byte and `cfg_inv_b2` inverts the three inserted B2 bytes.
- R11: With `cfg_scr_en` = 1, every byte from row 2 onward is XORed with the scrambler sequence. The 7-bit state is all ones at row 2 column 1, and each output bit is the state's top bit, most significant bit first. The next state shifts left and takes in (bit 6 XOR bit 5).
- R12: A word with `in_sof` high restarts the position at row 1, column 1, even in the middle of a frame. `out_sof` is high exactly on each frame's first output byte, and that byte ends the B1 and B2 accumulation windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | 24 | One byte per tributary, tributary k in bits [8k+7:8k] |
| in_sof | input | 1 | Word is row 1, column group 1 of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Outgoing STS-3 byte |
| out_sof | output | 1 | Output byte is the first byte of a frame |
| cfg_au4 | input | 1 | Concatenated pointer mode |
| cfg_sdh | input | 1 | Stuff value select: 1 gives 0xFF, 0 gives 0x00 |
| cfg_fill_pass | input | 1 | Unassigned overhead passes through from the tributary |
| cfg_scr_en | input | 1 | Scrambler enable |
| cfg_inv_b1 | input | 1 | Insert inverted B1 |
| cfg_inv_b2 | input | 1 | Insert inverted B2 bytes |
| cfg_j0 | input | 8 | Section trace byte |
| cfg_z0 | input | 16 | Growth bytes for columns 8 and 9 of row 1 |
| cfg_k1 | input | 8 | Protection byte K1 |
| cfg_k2 | input | 8 | Protection byte K2 |
| cfg_s1 | input | 8 | Synchronisation status byte |
| rx_b2_err | input | 8 | Count of received B2 errors, sent in M1 |

## Verification
The checker looks at the output handshake and the framing on every cycle. A stalled byte must hold steady. The first byte flagged by `out_sof` must be 0xF6. Counting taken bytes from that flag, the next bytes must be the A1 run, then the A2 run, then J0, whether the scrambler is on or off. The parity bytes, the scrambler sequence, the pointer bytes, the fill choices and the realignment in the middle of a frame depend on whole frames of history. Only the bench's reference model shows them, comparing every taken byte under varied back-pressure and provisioning.

// File: rtl/sts3_tx_pkg.sv
package sts3_tx_pkg;
  localparam logic [7:0] FRM_A1  = 8'hF6;
  localparam logic [7:0] FRM_A2  = 8'h28;
  localparam logic [7:0] PTR_H1  = 8'h6A;
  localparam logic [7:0] PTR_H2  = 8'h0A;
  localparam logic [7:0] CONC_H1 = 8'h9B;

  typedef struct packed {
    logic [7:0] key;
    logic [6:0] nxt;
  } scr_out_t;

  // Eight steps of the 1 + x^6 + x^7 generator, most significant bit first.
  function automatic scr_out_t scr_step(input logic [6:0] s);
    scr_out_t   r;
    logic [6:0] t;
    t = s;
    for (int i = 7; i >= 0; i--) begin
      r.key[i] = t[6];
      t = {t[5:0], t[6] ^ t[5]};
    end
    r.nxt = t;
    return r;
  endfunction
endpackage

// File: rtl/sts3_tx_ser.sv
module sts3_tx_ser #(
  parameter int N    = 3,
  parameter int ROWS = 9,
  parameter int COLS = 270,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS),
  localparam int SW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [8*N-1:0]  in_data,
  input  logic            in_sof,
  input  logic            adv,
  output logic            emit,
  output logic [7:0]      trib,
  output logic [RW-1:0]   row,
  output logic [CW-1:0]   col,
  output logic [SW-1:0]   slot
);
  logic           hold_vld, hold_sof;
  logic [8*N-1:0] hold_q;
  logic [SW-1:0]  slot_q;
  logic [RW-1:0]  row_q;
  logic [CW-1:0]  col_q;
  logic           last, restart, load;

  assign last     = (slot_q == SW'(N-1));
  assign emit     = hold_vld && adv;
  assign in_ready = !hold_vld || (emit && last);
  assign load     = in_valid && in_ready;
  assign restart  = hold_sof && (slot_q == '0);
  assign row      = restart ? '0 : row_q;
  assign col      = restart ? '0 : col_q;
  assign slot     = slot_q;
  assign trib     = hold_q[8*slot_q +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld <= 1'b0;
      hold_sof <= 1'b0;
      hold_q   <= '0;
      slot_q   <= '0;
      row_q    <= '0;
      col_q    <= '0;
    end else begin
      if (emit) begin
        slot_q   <= last ? '0 : slot_q + 1'b1;
        hold_sof <= 1'b0;
        if (last) hold_vld <= 1'b0;
        if (col == CW'(COLS-1)) begin
          col_q <= '0;
          row_q <= (row == RW'(ROWS-1)) ? '0 : row + 1'b1;
        end else begin
          col_q <= col + 1'b1;
          row_q <= row;
        end
      end
      if (load) begin
        hold_vld <= 1'b1;
        hold_q   <= in_data;
        hold_sof <= in_sof;
        slot_q   <= '0;
      end
    end
  end
endmodule

// File: rtl/sts3_tx_oh_sel.sv
module sts3_tx_oh_sel
  import sts3_tx_pkg::*;
#(
  parameter int N  = 3,
  parameter int CW = 9,
  parameter int RW = 4
) (
  input  logic [RW-1:0]      row,
  input  logic [CW-1:0]      col,
  input  logic [7:0]         trib,
  input  logic               cfg_au4,
  input  logic               cfg_sdh,
  input  logic               cfg_fill_pass,
  input  logic [7:0]         cfg_j0,
  input  logic [8*(N-1)-1:0] cfg_z0,
  input  logic [7:0]         cfg_k1,
  input  logic [7:0]         cfg_k2,
  input  logic [7:0]         cfg_s1,
  input  logic [7:0]         rx_b2_err,
  input  logic [7:0]         b1_ins,
  input  logic [7:0]         b2_ins,
  output logic [7:0]         pre
);
  int c, r, k, g;
  logic [7:0] fill;

  assign c    = int'(col);
  assign r    = int'(row);
  assign k    = c % N;
  assign g    = c / N;
  assign fill = cfg_fill_pass ? trib : (cfg_sdh ? 8'hFF : 8'h00);

  always_comb begin
    pre = trib;
    if (c < 3*N) begin
      pre = fill;
      if (r == 0) begin
        if (g == 0)      pre = FRM_A1;
        else if (g == 1) pre = FRM_A2;
        else             pre = (k == 0) ? cfg_j0 : cfg_z0[8*(k-1) +: 8];
      end else if (r == 1) begin
        if (c == 0) pre = b1_ins;
      end else if (r == 3) begin
        if (cfg_au4) begin
          if (g == 0)      pre = (k == 0) ? PTR_H1 : CONC_H1;
          else if (g == 1) pre = (k == 0) ? PTR_H2 : 8'hFF;
          else             pre = 8'hFF;
        end else begin
          pre = trib;
        end
      end else if (r == 4) begin
        if (g == 0)        pre = b2_ins;
        else if (c == N)   pre = cfg_k1;
        else if (c == 2*N) pre = cfg_k2;
      end else if (r == 8) begin
        if (c == 0)            pre = cfg_s1;
        else if (c == 2*N - 1) pre = rx_b2_err;
      end
    end
  end
endmodule

// File: rtl/sts3_tx_scr.sv
module sts3_tx_scr
  import sts3_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       skip,
  input  logic       reload,
  input  logic       en,
  output logic [7:0] mask
);
  logic [6:0] lfsr_q, cur;
  scr_out_t   so;

  assign cur  = reload ? 7'h7F : lfsr_q;
  assign so   = scr_step(cur);
  assign mask = (en && !skip) ? so.key : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lfsr_q <= 7'h7F;
    else if (step && !skip)  lfsr_q <= so.nxt;
  end
endmodule

// File: rtl/sts3_tx_bip.sv
module sts3_tx_bip #(
  parameter int N  = 3,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          emit,
  input  logic          frame_start,
  input  logic          in_soh,
  input  logic [SW-1:0] slot,
  input  logic [7:0]    pre,
  input  logic [7:0]    post,
  input  logic          inv_b1,
  input  logic          inv_b2,
  output logic [7:0]    b1_ins,
  output logic [7:0]    b2_ins
);
  logic [7:0]          b1_acc_q, b1_val_q;
  logic [N-1:0][7:0]   b2_acc_q, b2_val_q;

  assign b1_ins = b1_val_q ^ {8{inv_b1}};
  assign b2_ins = b2_val_q[slot] ^ {8{inv_b2}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b1_acc_q <= '0;
      b1_val_q <= '0;
    end else if (emit) begin
      if (frame_start) begin
        b1_val_q <= b1_acc_q;
        b1_acc_q <= post;
      end else begin
        b1_acc_q <= b1_acc_q ^ post;
      end
    end
  end

  for (genvar t = 0; t < N; t++) begin : g_b2
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        b2_acc_q[t] <= '0;
        b2_val_q[t] <= '0;
      end else if (emit) begin
        if (frame_start) begin
          b2_val_q[t] <= b2_acc_q[t];
          b2_acc_q[t] <= '0;
        end else if (!in_soh && slot == SW'(t)) begin
          b2_acc_q[t] <= b2_acc_q[t] ^ pre;
        end
      end
    end
  end
endmodule

// File: rtl/sts3_oh_tx.sv
module sts3_oh_tx #(
  parameter int N = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [8*N-1:0]     in_data,
  input  logic               in_sof,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_data,
  output logic               out_sof,
  input  logic               cfg_au4,
  input  logic               cfg_sdh,
  input  logic               cfg_fill_pass,
  input  logic               cfg_scr_en,
  input  logic               cfg_inv_b1,
  input  logic               cfg_inv_b2,
  input  logic [7:0]         cfg_j0,
  input  logic [8*(N-1)-1:0] cfg_z0,
  input  logic [7:0]         cfg_k1,
  input  logic [7:0]         cfg_k2,
  input  logic [7:0]         cfg_s1,
  input  logic [7:0]         rx_b2_err
);
  localparam int ROWS = 9;
  localparam int COLS = 90 * N;
  localparam int OHC  = 3 * N;
  localparam int CW   = $clog2(COLS);
  localparam int RW   = $clog2(ROWS);
  localparam int SW   = $clog2(N);

  logic          adv, emit;
  logic [7:0]    trib, pre, post, mask, b1_ins, b2_ins;
  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic [SW-1:0] slot;
  logic          frame_start, in_soh, row0, reload;

  assign adv         = !out_valid || out_ready;
  assign frame_start = (row == '0) && (col == '0);
  assign row0        = (row == '0);
  assign reload      = (row == RW'(1)) && (col == '0);
  assign in_soh      = (row < RW'(3)) && (col < CW'(OHC));
  assign post        = pre ^ mask;

  sts3_tx_ser #(.N(N), .ROWS(ROWS), .COLS(COLS)) u_ser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .adv(adv), .emit(emit),
    .trib(trib), .row(row), .col(col), .slot(slot)
  );

  sts3_tx_oh_sel #(.N(N), .CW(CW), .RW(RW)) u_sel (
    .row(row), .col(col), .trib(trib), .cfg_au4(cfg_au4), .cfg_sdh(cfg_sdh),
    .cfg_fill_pass(cfg_fill_pass), .cfg_j0(cfg_j0), .cfg_z0(cfg_z0),
    .cfg_k1(cfg_k1), .cfg_k2(cfg_k2), .cfg_s1(cfg_s1), .rx_b2_err(rx_b2_err),
    .b1_ins(b1_ins), .b2_ins(b2_ins), .pre(pre)
  );

  sts3_tx_scr u_scr (
    .clk(clk), .rst_n(rst_n), .step(emit), .skip(row0), .reload(reload),
    .en(cfg_scr_en), .mask(mask)
  );

  sts3_tx_bip #(.N(N), .SW(SW)) u_bip (
    .clk(clk), .rst_n(rst_n), .emit(emit), .frame_start(frame_start),
    .in_soh(in_soh), .slot(slot), .pre(pre), .post(post),
    .inv_b1(cfg_inv_b1), .inv_b2(cfg_inv_b2), .b1_ins(b1_ins), .b2_ins(b2_ins)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_data  <= post;
      out_sof   <= frame_start;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sts3_oh_tx_chk.sv
module sts3_oh_tx_chk #(
  parameter int N = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sof,
  input logic [7:0] cfg_j0
);
  logic [19:0] idx_q;
  logic        seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      seen_q <= 1'b0;
    end else if (out_valid && out_ready) begin
      if (out_sof) begin
        idx_q  <= 20'd1;
        seen_q <= 1'b1;
      end else if (idx_q != '1) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R3: a stalled byte is held
  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof));

  // R12: the flagged first byte opens the framing run
  p_sof_a1_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof |-> out_data == 8'hF6);

  // R2: framing run continues unscrambled
  p_a1_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_sof && seen_q && idx_q < 20'(N) |-> out_data == 8'hF6);

  p_a2_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_sof && seen_q && idx_q >= 20'(N) && idx_q < 20'(2*N)
    |-> out_data == 8'h28);

  p_j0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_sof && seen_q && idx_q == 20'(2*N) |-> out_data == cfg_j0);
endmodule

bind sts3_oh_tx sts3_oh_tx_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_sof(out_sof), .cfg_j0(cfg_j0)
);

// File: tb/sts3_oh_tx_bench.sv
module sts3_oh_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME_WORDS = 810;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, out_ready = 1'b0;
  logic [23:0] in_data = '0;
  logic        in_ready, out_valid, out_sof;
  logic [7:0]  out_data;
  logic        cfg_au4 = 0, cfg_sdh = 0, cfg_fill_pass = 0, cfg_scr_en = 0;
  logic        cfg_inv_b1 = 0, cfg_inv_b2 = 0;
  logic [7:0]  cfg_j0 = 8'h5C, cfg_k1 = 8'h13, cfg_k2 = 8'hA4, cfg_s1 = 8'h0F;
  logic [7:0]  rx_b2_err = 8'h21;
  logic [15:0] cfg_z0 = 16'hC3E1;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sts3_oh_tx u_sts3_oh_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof),
    .cfg_au4(cfg_au4), .cfg_sdh(cfg_sdh), .cfg_fill_pass(cfg_fill_pass),
    .cfg_scr_en(cfg_scr_en), .cfg_inv_b1(cfg_inv_b1), .cfg_inv_b2(cfg_inv_b2),
    .cfg_j0(cfg_j0), .cfg_z0(cfg_z0), .cfg_k1(cfg_k1), .cfg_k2(cfg_k2),
    .cfg_s1(cfg_s1), .rx_b2_err(rx_b2_err)
  );

  // Reference model state
  int m_row = 0, m_col = 0, m_lfsr = 127, m_b1acc = 0, m_b1val = 0;
  int m_b2acc[3] = '{0, 0, 0};
  int m_b2val[3] = '{0, 0, 0};
  int realign_left = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic       prev_stall = 0;
  logic [7:0] prev_data = '0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_word(input logic [23:0] w, input bit sof);
    for (int s = 0; s < 3; s++) begin
      int trib, pre, post, fill;
      string tg;
      if (s == 0 && sof) begin
        if (m_row != 0 || m_col != 0) realign_left = 9;
        m_row = 0; m_col = 0;
      end
      trib = int'(w[8*s +: 8]);
      fill = cfg_fill_pass ? trib : (cfg_sdh ? 255 : 0);
      if (m_row == 0 && m_col == 0) begin
        m_b1val = m_b1acc; m_b1acc = 0;
        for (int t = 0; t < 3; t++) begin m_b2val[t] = m_b2acc[t]; m_b2acc[t] = 0; end
      end
      tg = "R1"; pre = trib;
      if (m_col < 9) begin
        tg = "R7"; pre = fill;
        if (m_row == 0) begin
          tg = "R2";
          if (m_col < 3) pre = 'hF6;
          else if (m_col < 6) pre = 'h28;
          else if (m_col == 6) pre = cfg_j0;
          else if (m_col == 7) pre = cfg_z0[7:0];
          else pre = cfg_z0[15:8];
        end else if (m_row == 1 && m_col == 0) begin
          tg = cfg_inv_b1 ? "R10" : "R8";
          pre = cfg_inv_b1 ? (m_b1val ^ 255) : m_b1val;
        end else if (m_row == 3) begin
          if (!cfg_au4) begin tg = "R4"; pre = trib; end
          else begin
            tg = "R5";
            case (m_col)
              0: pre = 'h6A;
              1, 2: pre = 'h9B;
              3: pre = 'h0A;
              default: pre = 'hFF;
            endcase
          end
        end else if (m_row == 4 && m_col < 3) begin
          tg = cfg_inv_b2 ? "R10" : "R9";
          pre = cfg_inv_b2 ? (m_b2val[m_col] ^ 255) : m_b2val[m_col];
        end else if (m_row == 4 && m_col == 3) begin tg = "R6"; pre = cfg_k1; end
        else if (m_row == 4 && m_col == 6) begin tg = "R6"; pre = cfg_k2; end
        else if (m_row == 8 && m_col == 0) begin tg = "R6"; pre = cfg_s1; end
        else if (m_row == 8 && m_col == 5) begin tg = "R6"; pre = rx_b2_err; end
      end
      post = pre;
      if (m_row == 1 && m_col == 0) m_lfsr = 127;
      if (m_row != 0) begin
        int key = 0;
        for (int b = 0; b < 8; b++) begin
          int fb = ((m_lfsr >> 6) ^ (m_lfsr >> 5)) & 1;
          key = (key << 1) | ((m_lfsr >> 6) & 1);
          m_lfsr = ((m_lfsr << 1) | fb) & 127;
        end
        if (cfg_scr_en) begin post = pre ^ key; tg = {tg, "/R11"}; end
      end
      m_b1acc ^= post;
      if (!(m_row < 3 && m_col < 9)) m_b2acc[m_col % 3] ^= pre;
      if (realign_left > 0) begin tg = {tg, "/R12"}; realign_left--; end
      exp_q.push_back({(m_row == 0 && m_col == 0), 8'(post)});
      tag_q.push_back(tg);
      if (m_col == 269) begin m_col = 0; m_row = (m_row == 8) ? 0 : m_row + 1; end
      else m_col++;
    end
  endtask

  task automatic observe();
    if (prev_stall)
      check(out_valid && out_data == prev_data, "R3 stall hold",
            {out_valid, out_data}, {1'b1, prev_data});
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(0, "R1 unexpected byte", out_data, 0);
      else begin
        logic [8:0] e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        check({out_sof, out_data} == e, {tg, " byte/R12 sof"}, {out_sof, out_data}, e);
      end
    end
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
  endtask

  task automatic run_scen(input int nwords, input int rs, input int pin, input int pout);
    int w = 0;
    while (w < nwords || exp_q.size() > 0 || out_valid) begin
      @(negedge clk);
      out_ready = (w >= nwords) || (($urandom % 100) < pout);
      in_valid  = (w < nwords) && (($urandom % 100) < pin);
      in_data   = 24'($urandom);
      in_sof    = (w == 0) || (w >= rs && ((w - rs) % FRAME_WORDS) == 0);
      #1;
      observe();
      if (in_valid && in_ready) begin
        model_word(in_data, in_sof);
        w++;
      end
    end
    @(negedge clk);
    in_valid = 0;
    out_ready = 1;
    #1;
    observe();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 0, "R3 reset out_valid", out_valid, 0);
    check(in_ready == 1, "R3 reset in_ready", in_ready, 1);
    rst_n = 1'b1;
    // S1: plain SONET, no stalls, stuff fill
    run_scen(1700, FRAME_WORDS, 100, 100);
    // S2: scrambler on, pass-through fill, heavy back-pressure
    cfg_scr_en = 1; cfg_fill_pass = 1;
    run_scen(1700, FRAME_WORDS, 70, 60);
    // S3: concatenated mode, SDH stuff, inverted parity
    cfg_au4 = 1; cfg_sdh = 1; cfg_fill_pass = 0; cfg_inv_b1 = 1; cfg_inv_b2 = 1;
    cfg_j0 = 8'h77; rx_b2_err = 8'h05;
    run_scen(1700, FRAME_WORDS, 90, 80);
    // S4: realign in mid-frame, then full frames
    cfg_au4 = 0; cfg_sdh = 0; cfg_scr_en = 0; cfg_inv_b1 = 0; cfg_inv_b2 = 0;
    run_scen(1800, 100, 100, 100);
    // S5: scrambled SDH with stuff fill after realignment history
    cfg_scr_en = 1; cfg_sdh = 1;
    run_scen(1000, FRAME_WORDS, 85, 75);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule